// File: doc/BRIEF.md
# Daisy-Chain Serial Loader

This block sits on the host side of a chain of cascaded shift-register output devices and loads the whole chain in one transaction. Each device in the chain samples its serial input on the rising edge of the shared serial clock and passes the bits it shifts out to the next device. The loader accepts a parallel word whose length is the sum of the register lengths in the chain, for example 18 bits for an 8-bit device followed by a 10-bit device. It shifts that word out one bit per clock, waits a minimum delay, and then drives a single latch pulse. That pulse updates every device in the chain at the same moment.

Every timing limit of the serial link is a count of system-clock cycles, captured when a transfer starts. These limits are the clock low time, the clock high time, the data setup time ahead of a rising edge, the delay from the final clock edge to the latch pulse, and the width of the latch pulse. A count of zero is treated as one cycle. The host uses a start/busy/done handshake: it pulses `start` while the block is idle and waits for `done`.

Top module: `daisy_loader`

## Requirements
- R1: After reset and whenever `busy` is low, `sck`, `si`, `strobe` and `done` are all low.
- R2: A `start` pulse seen while `busy` is low makes `busy` rise on the next clock edge. A `start` seen while `busy` is high is ignored: it starts no new frame and does not cut the current frame short.
- R3: A frame of length N gives exactly N rising `sck` edges. `si` carries `frame_data[N-1]` at the first rising edge and `frame_data[0]` at the last, so the bit meant for the farthest device goes first.
- R4: Before every rising `sck` edge, `sck` is low for exactly max(`clk_low_cnt`, `setup_cnt`, 1) cycles, counted from the rise of `busy` or from the previous falling edge. `si` changes only in the cycle where `busy` rises or `sck` falls, and it stays stable at all other times while `busy` is high.
- R5: Every high phase of `sck` lasts exactly max(`clk_high_cnt`, 1) cycles.
- R6: After the last falling `sck` edge, `sck` stays low for exactly max(`gap_cnt`, 1) cycles, and then `strobe` rises.
- R7: `strobe` rises once per frame, stays high for exactly max(`strobe_cnt`, 1) cycles, and `sck` is low throughout.
- R8: `done` is high for exactly one cycle: the first cycle after `strobe` falls. `busy` falls on the next edge.
- R9: A frame length of zero gives no `sck` edge. `strobe` rises max(`gap_cnt`, 1) cycles after `busy` rises.
- R10: A frame length above `MAX_BITS` is clamped to `MAX_BITS`, and the shifting starts from `frame_data[MAX_BITS-1]`.
- R11: Frame length, data and all five timing counts are captured at the accepted `start`. Changing them while `busy` is high has no effect on the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to begin a frame (accepted only while idle) |
| frame_len | input | LEN_W | Number of bits in the frame (sum of chain lengths) |
| frame_data | input | MAX_BITS | Frame contents, bit 0 last out |
| clk_low_cnt | input | CNT_W | Minimum serial-clock low time, in cycles |
| clk_high_cnt | input | CNT_W | Minimum serial-clock high time, in cycles |
| setup_cnt | input | CNT_W | Minimum data setup before a rising edge, in cycles |
| gap_cnt | input | CNT_W | Minimum delay from last clock edge to latch pulse |
| strobe_cnt | input | CNT_W | Minimum latch-pulse width, in cycles |
| sck | output | 1 | Serial clock to the chain, idles low |
| si | output | 1 | Serial data to the first device of the chain |
| strobe | output | 1 | Latch pulse shared by all chained devices |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench measures every low phase, high phase, gap and latch width in cycles and compares each one with the expected maximum-of-counts value. A design that used only the clock low time and ignored the setup count would produce low phases that are too short when the setup count is larger. Zero counts, a zero-length frame and an over-long frame are all driven. A design that handled these wrongly would emit a spurious clock edge, underflow its bit counter, or shift garbage from above the data word. The bench also pulses `start` during a frame and changes every input while `busy` is high. A design that restarts on that pulse, or that reads its inputs live, would produce an extra frame or wrong bits and widths, and the bench's scoreboard queue would show the mismatch.

// File: rtl/dl_pkg.sv
// Package: shared definitions for the daisy-chain serial loader.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package dl_pkg;

    // Phases of one frame transfer.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,   // waiting for start
        ST_LOW  = 3'd1,   // serial clock low, data presented
        ST_HIGH = 3'd2,   // serial clock high, devices have sampled
        ST_GAP  = 3'd3,   // clock-to-latch delay
        ST_STB  = 3'd4,   // latch pulse high
        ST_DONE = 3'd5    // completion cycle
    } dl_state_e;

endpackage

// File: rtl/dl_phase_timer.sv
// Module: dl_phase_timer
// A down-counter that times one phase of the transfer. Loading a value N
// makes expired go high in the N-th cycle of the phase (N = 0 counts as 1).
// Assumes the owner reloads the timer only when it has expired or was idle.
module dl_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Count the current phase down toward one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q > CNT_W'(1)) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // Phase ends in the cycle where the count reaches one (or is zero).
    assign expired = (cnt_q <= CNT_W'(1));

    // A new phase may only be loaded once the previous one has run out.
    p_load_after_expire_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> expired);

endmodule

// File: rtl/dl_bit_seq.sv
// Module: dl_bit_seq
// Holds the frame left-justified in a shift register so that the bit meant
// for the farthest device appears first on bit_out, and counts the bits
// that remain. Over-long lengths are clamped to MAX_BITS.
// Assumes advance is only asserted while bits remain.
module dl_bit_seq #(
    parameter int MAX_BITS = 32,
    parameter int LEN_W    = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [LEN_W-1:0]    len,
    input  logic [MAX_BITS-1:0] data,
    input  logic                advance,
    output logic                bit_out,
    output logic                last
);

    localparam int CW = $clog2(MAX_BITS + 1);

    logic [MAX_BITS-1:0] shreg_q;
    logic [CW-1:0]       rem_q;
    logic [CW-1:0]       len_eff;

    // Clamp the requested length to the register size.
    always_comb begin
        if (len > LEN_W'(MAX_BITS)) begin
            len_eff = CW'(MAX_BITS);
        end else begin
            len_eff = len[CW-1:0];
        end
    end

    // Load the frame left-justified, then shift one bit per completed clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
            rem_q   <= '0;
        end else if (load) begin
            shreg_q <= data << (MAX_BITS - int'(len_eff));
            rem_q   <= len_eff;
        end else if (advance) begin
            shreg_q <= {shreg_q[MAX_BITS-2:0], 1'b0};
            rem_q   <= rem_q - CW'(1);
        end
    end

    assign bit_out = shreg_q[MAX_BITS-1];
    assign last    = (rem_q == CW'(1));

    // The bit counter never steps below zero.
    p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> (rem_q != '0));

    // Once the final bit is shifted, the serial data line returns to zero.
    p_zero_after_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && last) |=> !bit_out);

endmodule

// File: rtl/daisy_loader.sv
// Module: daisy_loader (top)
// Shifts a frame of programmable length into a chain of cascaded serial
// shift-register devices, then drives one latch pulse for the whole chain.
// Timing limits are cycle counts captured at start; a zero count is one cycle.
// Assumes the devices sample si on the rising edge of sck.
module daisy_loader #(
    parameter int MAX_BITS = 32,
    parameter int LEN_W    = 7,
    parameter int CNT_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [LEN_W-1:0]    frame_len,
    input  logic [MAX_BITS-1:0] frame_data,
    input  logic [CNT_W-1:0]    clk_low_cnt,
    input  logic [CNT_W-1:0]    clk_high_cnt,
    input  logic [CNT_W-1:0]    setup_cnt,
    input  logic [CNT_W-1:0]    gap_cnt,
    input  logic [CNT_W-1:0]    strobe_cnt,
    output logic                sck,
    output logic                si,
    output logic                strobe,
    output logic                busy,
    output logic                done
);

    import dl_pkg::*;

    dl_state_e        st_q, st_n;
    logic [CNT_W-1:0] low_q, high_q, gap_q, stb_q;
    logic [CNT_W-1:0] low_in;
    logic             t_load, t_exp;
    logic [CNT_W-1:0] t_val;
    logic             s_load, s_adv, s_last, s_bit;
    logic             sck_q, strobe_q, busy_q, done_q;

    // The low phase must cover both the clock low time and the data setup.
    assign low_in = (clk_low_cnt > setup_cnt) ? clk_low_cnt : setup_cnt;

    dl_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_exp)
    );

    dl_bit_seq #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (s_load),
        .len     (frame_len),
        .data    (frame_data),
        .advance (s_adv),
        .bit_out (s_bit),
        .last    (s_last)
    );

    // Next-phase decision and timer/sequencer control.
    always_comb begin
        st_n   = st_q;
        t_load = 1'b0;
        t_val  = '0;
        s_load = 1'b0;
        s_adv  = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (start) begin
                    s_load = 1'b1;
                    t_load = 1'b1;
                    if (frame_len == '0) begin
                        st_n  = ST_GAP;
                        t_val = gap_cnt;
                    end else begin
                        st_n  = ST_LOW;
                        t_val = low_in;
                    end
                end
            end
            ST_LOW: begin
                if (t_exp) begin
                    st_n   = ST_HIGH;
                    t_load = 1'b1;
                    t_val  = high_q;
                end
            end
            ST_HIGH: begin
                if (t_exp) begin
                    s_adv  = 1'b1;
                    t_load = 1'b1;
                    if (s_last) begin
                        st_n  = ST_GAP;
                        t_val = gap_q;
                    end else begin
                        st_n  = ST_LOW;
                        t_val = low_q;
                    end
                end
            end
            ST_GAP: begin
                if (t_exp) begin
                    st_n   = ST_STB;
                    t_load = 1'b1;
                    t_val  = stb_q;
                end
            end
            ST_STB: begin
                if (t_exp) begin
                    st_n = ST_DONE;
                end
            end
            ST_DONE: begin
                st_n = ST_IDLE;
            end
            default: begin
                st_n = ST_IDLE;
            end
        endcase
    end

    // Phase register and registered outputs decoded from the next phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            sck_q    <= 1'b0;
            strobe_q <= 1'b0;
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            st_q     <= st_n;
            sck_q    <= (st_n == ST_HIGH);
            strobe_q <= (st_n == ST_STB);
            busy_q   <= (st_n != ST_IDLE);
            done_q   <= (st_n == ST_DONE);
        end
    end

    // Capture the timing counts when a frame is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q  <= '0;
            high_q <= '0;
            gap_q  <= '0;
            stb_q  <= '0;
        end else if (st_q == ST_IDLE && start) begin
            low_q  <= low_in;
            high_q <= clk_high_cnt;
            gap_q  <= gap_cnt;
            stb_q  <= strobe_cnt;
        end
    end

    assign sck    = sck_q;
    assign si     = s_bit;
    assign strobe = strobe_q;
    assign busy   = busy_q;
    assign done   = done_q;

    // Idle means all link lines and the completion flag are low.
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sck && !strobe && !done && !si));

    // A frame in progress runs until its completion cycle, start or not.
    p_no_abort_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // Data is held across each high phase of the serial clock.
    p_si_hold_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(si));

    // Data moves only on a falling clock edge or at frame start.
    p_si_low_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !sck && !$past(sck)) |-> $stable(si));

    // The latch pulse never overlaps a high clock.
    p_strobe_sck_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> !sck);

    // Completion directly follows the end of the latch pulse.
    p_done_after_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(strobe) && !strobe));

    // Completion lasts one cycle and ends the busy period.
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

endmodule

// File: tb/tb_daisy_loader.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes the expected frame, the monitor pops
// it at the rise of busy and measures every phase of the serial link.
module tb_daisy_loader;

    localparam int MAX_BITS = 32;
    localparam int LEN_W    = 7;
    localparam int CNT_W    = 8;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start = 1'b0;
    logic [LEN_W-1:0]    frame_len = '0;
    logic [MAX_BITS-1:0] frame_data = '0;
    logic [CNT_W-1:0]    clk_low_cnt = '0, clk_high_cnt = '0, setup_cnt = '0;
    logic [CNT_W-1:0]    gap_cnt = '0, strobe_cnt = '0;
    logic                sck, si, strobe, busy, done;

    always #2.5 clk = ~clk;

    daisy_loader #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .frame_len(frame_len),
        .frame_data(frame_data), .clk_low_cnt(clk_low_cnt),
        .clk_high_cnt(clk_high_cnt), .setup_cnt(setup_cnt), .gap_cnt(gap_cnt),
        .strobe_cnt(strobe_cnt), .sck(sck), .si(si), .strobe(strobe),
        .busy(busy), .done(done)
    );

    typedef struct {
        int          len;
        bit          clamped;
        logic [63:0] data;
        int          low, high, gap, stb;
    } exp_t;

    exp_t q[$];
    int n_chk = 0, n_fail = 0, pushed = 0, seen = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int mx1(input int a);
        return (a < 1) ? 1 : a;
    endfunction

    // Drive one frame and push its expectation; optionally disturb it while busy.
    task automatic run_frame(input int len, input logic [31:0] data, input int tl,
                             input int th, input int ts, input int tg, input int tb,
                             input bit disturb);
        exp_t e;
        int eff;
        eff       = (len > MAX_BITS) ? MAX_BITS : len;
        e.len     = eff;
        e.clamped = (len > MAX_BITS);
        e.data    = (eff == 0) ? 64'd0 : ({32'd0, data} & ((64'd1 << eff) - 64'd1));
        e.low     = mx1((tl > ts) ? tl : ts);
        e.high    = mx1(th);
        e.gap     = mx1(tg);
        e.stb     = mx1(tb);
        q.push_back(e);
        pushed++;
        @(negedge clk);
        frame_len    = LEN_W'(len);
        frame_data   = data;
        clk_low_cnt  = CNT_W'(tl);
        clk_high_cnt = CNT_W'(th);
        setup_cnt    = CNT_W'(ts);
        gap_cnt      = CNT_W'(tg);
        strobe_cnt   = CNT_W'(tb);
        start        = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2 busy after start", busy, 1);
        if (disturb) begin
            // R11 inputs changed mid-frame; R2 start while busy is ignored.
            @(negedge clk);
            frame_data   = ~data;
            frame_len    = LEN_W'(5);
            clk_low_cnt  = 8'd7;
            clk_high_cnt = 8'd7;
            setup_cnt    = 8'd7;
            gap_cnt      = 8'd7;
            strobe_cnt   = 8'd7;
            start        = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: pop the expectation at busy rise and measure every phase.
    exp_t cur;
    bit   active = 1'b0;
    int   run = 0, nb = 0;
    logic [63:0] cap = '0;
    logic p_sck = 1'b0, p_si = 1'b0, p_strobe = 1'b0, p_busy = 1'b0, p_done = 1'b0;

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (busy && !p_busy) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R2 unexpected frame", 1, 0);
                    active = 1'b0;
                end else begin
                    cur = q.pop_front();
                    active = 1'b1;
                end
                run = 1; nb = 0; cap = '0;
                chk(!sck && !strobe, "R4 frame opens with sck low", sck, 0);
            end else if (busy && active) begin
                if (sck && !p_sck) begin
                    chk(run == cur.low, "R4 low phase width", run, cur.low);
                    cap = {cap[62:0], si};
                    nb++;
                    run = 1;
                end else if (!sck && p_sck) begin
                    chk(run == cur.high, "R5 high phase width", run, cur.high);
                    run = 1;
                end else if (strobe && !p_strobe) begin
                    if (cur.len == 0)
                        chk(run == cur.gap, "R9 empty frame latch delay", run, cur.gap);
                    else
                        chk(run == cur.gap, "R6 clock to latch delay", run, cur.gap);
                    chk(nb == cur.len, cur.clamped ? "R10 clamped bit count" : "R3 bit count",
                        nb, cur.len);
                    chk(cap == cur.data, cur.clamped ? "R10 clamped data" : "R3 shifted data",
                        cap, cur.data);
                    run = 1;
                end else if (!strobe && p_strobe) begin
                    chk(run == cur.stb, "R7 latch width", run, cur.stb);
                    chk(done == 1'b1, "R8 done after latch", done, 1);
                end else begin
                    run++;
                    if (si !== p_si) chk(1'b0, "R4 si moved outside falling edge", si, p_si);
                    if (strobe && sck) chk(1'b0, "R7 sck high during latch", sck, 0);
                end
            end
            if (done && !(p_strobe && !strobe)) chk(1'b0, "R8 stray done", done, 0);
            if (!busy && p_busy) begin
                chk(p_done == 1'b1, "R8 busy ends after done", p_done, 1);
                active = 1'b0;
                seen++;
            end
            if (!busy && (sck || strobe || done || si))
                chk(1'b0, "R1 idle lines", {sck, strobe, done, si}, 0);
            p_sck = sck; p_si = si; p_strobe = strobe; p_busy = busy; p_done = done;
        end
    end

    task automatic report();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        report();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        chk({sck, si, strobe, busy, done} == 5'b0, "R1 reset outputs",
            {sck, si, strobe, busy, done}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({sck, si, strobe, busy, done} == 5'b0, "R1 idle after reset",
            {sck, si, strobe, busy, done}, 0);
        // R3 18-bit chain, R4..R8 timing
        run_frame(18, 32'h0002A5C3, 2, 3, 1, 4, 3, 1'b0);
        // R4 setup count larger than low count
        run_frame(8, 32'h000000A5, 1, 1, 5, 1, 1, 1'b0);
        // zero counts give one-cycle phases, single bit
        run_frame(1, 32'h00000001, 0, 0, 0, 0, 0, 1'b0);
        // R9 zero-length frame
        run_frame(0, 32'hFFFFFFFF, 2, 2, 2, 3, 2, 1'b0);
        // R10 over-long frame clamped
        run_frame(40, 32'hDEADBEEF, 1, 2, 0, 2, 1, 1'b0);
        // R11 and R2: disturbed full-width frame
        run_frame(32, 32'h80000001, 3, 2, 2, 5, 4, 1'b1);
        // R3 all ones
        run_frame(18, 32'h0003FFFF, 1, 1, 1, 1, 2, 1'b0);
        repeat (10) @(negedge clk);
        chk(seen == pushed, "R2 frame count", seen, pushed);
        chk(q.size() == 0, "R2 all frames observed", q.size(), 0);
        report();
    end

endmodule